// File: doc/BRIEF.md
# Left-Aligned PWM Channel with Selectable Polarity

This block produces one pulse-width modulated output in left-aligned form. An internal counter steps from zero up to one below the programmed period and then returns to zero, so one output period lasts as many count ticks as the period value. The counter is compared with a duty value. A polarity setting decides whether the output starts each period high or low. The output moves to the other level when the counter reaches the duty value.

The counter advances only on ticks from one of four prescaled tick inputs. These inputs are made outside the block: bit 0 is clock A, bit 1 is clock B, bit 2 is scaled A and bit 3 is scaled B. A two-bit select input chooses one of them. Period and duty values are written through a small register port into shadow registers. The running channel picks up new values only at a period boundary or while it is disabled, so a period is never cut short. Polarity and tick-source selection are sampled only while the channel is disabled. Software therefore sets them up first and then enables the channel.

Top module: `pwm_la_channel`

## Requirements
- R1: After reset the counter is 0, the period and duty registers are 0, polarity is 0 and the output is 1.
- R2: While `enable_i` is 0, the output equals the inverse of the polarity setting sampled at the last clock edge, and the counter is held at 0.
- R3: While enabled, the counter advances only in cycles where `tick_i[sel]` is 1, where sel is the latched tick-source select (0 = A, 1 = B, 2 = scaled A, 3 = scaled B). Ticks on the other inputs have no effect.
- R4: On a selected tick, the counter increments when counter+1 is below the active period. Otherwise it returns to 0. The output therefore repeats every period-value ticks.
- R5: While running with a nonzero period, the output equals the polarity when the counter is below the active duty, and its inverse otherwise. With polarity 1 the high time is duty/period. With polarity 0 it is (period-duty)/period.
- R6: A duty of 0 gives a constant output equal to the inverse of polarity. A duty at or above the period gives a constant output equal to polarity.
- R7: An active period of 0 holds the output at the inverse of polarity.
- R8: A write with `wr_addr_i` = 0 sets the shadow period and `wr_addr_i` = 1 sets the shadow duty. The shadow values are copied to the active registers at every clock edge while disabled, and at the wrap of the counter while enabled.
- R9: `polarity_i` and `sel_i` are latched only while `enable_i` is 0. Changes made while the channel is enabled do not affect the output.
- R10: With period 4, duty 1, polarity 0 and a tick in every cycle, the output is high for 3 of every 4 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 4 | Prescaled tick enables: A, B, scaled A, scaled B |
| sel_i | input | 2 | Tick-source select, latched while disabled |
| polarity_i | input | 1 | Starting level of each period, latched while disabled |
| enable_i | input | 1 | Channel run enable |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 1 | 0 = period, 1 = duty |
| wr_data_i | input | 8 | Write data |
| pwm_o | output | 1 | PWM output |

## Verification
Internal state reaches `pwm_o` directly. A counter that is off by one, or that wraps late, shifts the output edge within the current period, and the check at the next cycle catches it. An active register loaded at the wrong moment, or a polarity latched while running, changes the level in the first period after the fault. The bench compares the output with a model in every cycle, so such a fault shows up within one period of the stimulus that exposes it.

// File: rtl/pwm_la_pkg.sv
package pwm_la_pkg;
  localparam int unsigned N_SRC = 4;
  localparam int unsigned SEL_W = $clog2(N_SRC);

  typedef enum logic {
    REG_PERIOD = 1'b0,
    REG_DUTY   = 1'b1
  } pwm_reg_e;
endpackage

// File: rtl/pwm_la_regs.sv
module pwm_la_regs #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             wr_addr_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic             load_i,
  output logic [CNT_W-1:0] per_o,
  output logic [CNT_W-1:0] dty_o
);
  import pwm_la_pkg::*;

  logic [CNT_W-1:0] per_buf_q, dty_buf_q;
  logic [CNT_W-1:0] per_act_q, dty_act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      per_buf_q <= '0;
      dty_buf_q <= '0;
    end else if (wr_en_i) begin
      if (pwm_reg_e'(wr_addr_i) == REG_PERIOD) per_buf_q <= wr_data_i;
      else                                      dty_buf_q <= wr_data_i;
    end
  end

  // active copy only moves at a period boundary or while stopped
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      per_act_q <= '0;
      dty_act_q <= '0;
    end else if (load_i) begin
      per_act_q <= per_buf_q;
      dty_act_q <= dty_buf_q;
    end
  end

  assign per_o = per_act_q;
  assign dty_o = dty_act_q;
endmodule

// File: rtl/pwm_la_cfg.sv
module pwm_la_cfg
  import pwm_la_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic [N_SRC-1:0] tick_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             polarity_i,
  output logic             pol_o,
  output logic [SEL_W-1:0] sel_o,
  output logic             tick_o
);
  logic             pol_q;
  logic [SEL_W-1:0] sel_q;
  logic [N_SRC-1:0] hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pol_q <= 1'b0;
      sel_q <= '0;
    end else if (!enable_i) begin
      pol_q <= polarity_i;
      sel_q <= sel_i;
    end
  end

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    assign hit[g] = tick_i[g] && (sel_q == SEL_W'(g));
  end

  assign tick_o = |hit;
  assign pol_o  = pol_q;
  assign sel_o  = sel_q;
endmodule

// File: rtl/pwm_la_counter.sv
module pwm_la_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] per_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             run_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             run_q;
  logic [CNT_W:0]   cnt_nx;

  assign cnt_nx = {1'b0, cnt_q} + (CNT_W+1)'(1);
  // per_i == 0 also counts as a boundary so a new period can load
  assign wrap_o = enable_i && tick_i && (cnt_nx >= {1'b0, per_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (!enable_i) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else begin
      run_q <= 1'b1;
      if (wrap_o)      cnt_q <= '0;
      else if (tick_i) cnt_q <= cnt_nx[CNT_W-1:0];
    end
  end

  assign cnt_o = cnt_q;
  assign run_o = run_q;
endmodule

// File: rtl/pwm_la_compare.sv
module pwm_la_compare #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             run_i,
  input  logic             pol_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] per_i,
  input  logic [CNT_W-1:0] dty_i,
  output logic             pwm_o
);
  always_comb begin
    if (!run_i || per_i == '0) pwm_o = ~pol_i;
    else if (cnt_i < dty_i)    pwm_o = pol_i;
    else                       pwm_o = ~pol_i;
  end
endmodule

// File: rtl/pwm_la_channel.sv
module pwm_la_channel
  import pwm_la_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] tick_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             polarity_i,
  input  logic             enable_i,
  input  logic             wr_en_i,
  input  logic             wr_addr_i,
  input  logic [CNT_W-1:0] wr_data_i,
  output logic             pwm_o
);
  logic [CNT_W-1:0] cnt_q, per_act, dty_act;
  logic             run_q, pol_q, tick_hit, wrap;
  logic [SEL_W-1:0] sel_q;
  logic             load;

  assign load = !enable_i || wrap;

  pwm_la_cfg i_cfg (
    .clk_i, .rst_ni, .enable_i, .tick_i, .sel_i, .polarity_i,
    .pol_o (pol_q), .sel_o (sel_q), .tick_o (tick_hit)
  );

  pwm_la_regs #(.CNT_W(CNT_W)) i_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .load_i (load), .per_o (per_act), .dty_o (dty_act)
  );

  pwm_la_counter #(.CNT_W(CNT_W)) i_cnt (
    .clk_i, .rst_ni, .enable_i, .tick_i (tick_hit), .per_i (per_act),
    .cnt_o (cnt_q), .run_o (run_q), .wrap_o (wrap)
  );

  pwm_la_compare #(.CNT_W(CNT_W)) i_cmp (
    .run_i (run_q), .pol_i (pol_q), .cnt_i (cnt_q), .per_i (per_act),
    .dty_i (dty_act), .pwm_o
  );
endmodule

// File: rtl/pwm_la_channel_chk.sv
module pwm_la_channel_chk
  import pwm_la_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             enable_i,
  input logic             polarity_i,
  input logic             pwm_o,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] per_act,
  input logic             run_q,
  input logic             pol_q,
  input logic [SEL_W-1:0] sel_q,
  input logic             tick_hit,
  input logic             wrap
);
  // R2
  off_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> (pwm_o == ~$past(polarity_i)) && (cnt_q == '0));

  // R4
  cnt_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && per_act != '0) |-> (cnt_q < per_act));

  // R3
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && tick_hit && !wrap) |=> (cnt_q == $past(cnt_q) + 1'b1));

  // R3
  cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && !tick_hit) |=> $stable(cnt_q));

  // R9
  cfg_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enable_i |=> ($stable(pol_q) && $stable(sel_q)));

  // R7
  zero_period_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (per_act == '0) |-> (pwm_o != pol_q));
endmodule

bind pwm_la_channel pwm_la_channel_chk #(.CNT_W(CNT_W)) i_chk (
  .clk_i, .rst_ni, .enable_i, .polarity_i, .pwm_o,
  .cnt_q, .per_act, .run_q, .pol_q, .sel_q, .tick_hit, .wrap
);

// File: tb/test_pwm_la_channel.sv
module test_pwm_la_channel;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [3:0]   tick = '0;
  logic [1:0]   sel = '0;
  logic         pol = 1'b0;
  logic         en = 1'b0;
  logic         wr_en = 1'b0;
  logic         wr_addr = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic         pwm;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0;

  // reference state, built from the requirements
  int m_cnt = 0, m_per = 0, m_dty = 0, m_pbuf = 0, m_dbuf = 0, m_sel = 0;
  bit m_pol = 0, m_run = 0;

  pwm_la_channel #(.CNT_W(W)) i_pwm_la_channel (
    .clk_i (clk), .rst_ni (rst_n), .tick_i (tick), .sel_i (sel),
    .polarity_i (pol), .enable_i (en), .wr_en_i (wr_en), .wr_addr_i (wr_addr),
    .wr_data_i (wr_data), .pwm_o (pwm)
  );

  always #5 clk = ~clk;

  function automatic bit exp_out();
    if (!m_run || m_per == 0) return ~m_pol;
    return (m_cnt < m_dty) ? m_pol : ~m_pol;
  endfunction

  task automatic check(input string req, input bit act, input bit exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: pwm_o=%0b expected %0b (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic check_int(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  // one clock: advance the model on the driven inputs, then compare
  task automatic step(input string req);
    if (!en) begin
      m_run = 0; m_cnt = 0; m_per = m_pbuf; m_dty = m_dbuf;
      m_pol = pol; m_sel = int'(sel);
    end else begin
      m_run = 1;
      if (tick[m_sel]) begin
        if (m_cnt + 1 >= m_per) begin
          m_cnt = 0; m_per = m_pbuf; m_dty = m_dbuf;
        end else m_cnt++;
      end
    end
    if (wr_en) begin
      if (wr_addr) m_dbuf = int'(wr_data);
      else         m_pbuf = int'(wr_data);
    end
    @(posedge clk);
    @(negedge clk);
    cyc++;
    wr_en = 1'b0;
    check(req, pwm, exp_out());
  endtask

  task automatic wr(input bit a, input int d);
    wr_en = 1'b1; wr_addr = a; wr_data = W'(d);
    step("R8");
  endtask

  task automatic count_high(input int n, input string req, output int hi);
    hi = 0;
    for (int i = 0; i < n; i++) begin
      step(req);
      if (pwm) hi++;
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: run did not finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin : main
    int hi;
    void'($urandom(32'h5eed));
    repeat (2) @(negedge clk);
    // R1
    check("R1", pwm, 1'b1);
    rst_n = 1'b1;
    step("R1");

    // R10: period 4, duty 1, polarity 0, tick every cycle
    wr(0, 4); wr(1, 1);
    tick = 4'hf; pol = 1'b0; sel = 2'd0;
    step("R2");
    en = 1'b1;
    count_high(8, "R10", hi);
    check_int("R10 high cycles in two periods", hi, 6);

    // R9: polarity change while running has no effect
    pol = 1'b1; sel = 2'd3;
    count_high(8, "R9", hi);
    check_int("R9 high cycles with polarity_i flipped", hi, 6);

    // R6: duty 0 -> constant inverse polarity (1)
    wr(1, 0);
    count_high(4, "R6", hi);
    count_high(8, "R6", hi);
    check_int("R6 duty 0 high cycles", hi, 8);
    // R6: duty above period -> constant polarity (0)
    wr(1, 9);
    count_high(4, "R6", hi);
    count_high(8, "R6", hi);
    check_int("R6 duty over period high cycles", hi, 0);

    // R2: disable latches polarity 1, output goes to 0
    en = 1'b0;
    step("R2");
    check("R2", pwm, 1'b0);

    // R7: period 0 holds inactive level while running
    wr(0, 0); wr(1, 2);
    en = 1'b1;
    count_high(6, "R7", hi);
    check_int("R7 period 0 high cycles", hi, 0);
    en = 1'b0;

    // R3: select scaled A (2); ticks on other inputs are ignored
    wr(0, 4); wr(1, 2); pol = 1'b1; sel = 2'd2; tick = 4'b1011;
    step("R3");
    en = 1'b1;
    count_high(6, "R3", hi);
    check_int("R3 no selected tick keeps counter at 0", hi, 6);
    tick = 4'b0100;
    count_high(8, "R3", hi);
    check_int("R3 selected tick high cycles", hi, 4);

    // R4: period 5, duty 2, polarity 1: level repeats every 5 ticks
    wr(0, 5);
    count_high(5, "R4", hi);
    count_high(10, "R4", hi);
    check_int("R4 high cycles in two 5-tick periods", hi, 4);

    // random mix, compared with the model every cycle
    for (int i = 0; i < 3000; i++) begin
      tick    = 4'($urandom);
      if ($urandom_range(0, 40) == 0) en = ~en;
      if ($urandom_range(0, 10) == 0) pol = 1'($urandom);
      if ($urandom_range(0, 10) == 0) sel = 2'($urandom);
      if ($urandom_range(0, 12) == 0) begin
        wr_en = 1'b1; wr_addr = 1'($urandom);
        wr_data = W'($urandom_range(0, 12));
      end
      step("R4 R5 R8");
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule